// File: doc/BRIEF.md
# DSP Address Generation Unit

This block forms data-memory addresses for a DSP datapath using register-indirect addressing. It holds a bank of pointer registers. Each pointer has its own step register and its own buffer-length register. When a request arrives, the unit reads the selected pointer and the mode code. It then produces a registered effective address one cycle later. In the same cycle it can write an updated value back into the pointer.

The unit supports several addressing forms:
- plain indirect;
- pre-step and post-step by one, in either direction;
- indexed, either by a signed constant from the instruction or by the step register, with no write-back;
- step by the step register, with a selectable direction and a selectable ordering.

When a pointer's length register is non-zero, every write-back of that pointer wraps inside a circular buffer. The buffer sits on a boundary of K words, where K is the smallest power of two not below the length. When the length is zero, arithmetic is linear modulo 2^16. Software loads the pointer, step and length registers through a simple write port, and reads any of them back through a combinational read port.

Top module: `agu_top`

## Requirements
- R1: After reset every pointer, step and length register reads back as zero and `ea_valid` is low.
- R2: A request (`req` high) makes `ea_valid` high in the next cycle. An idle cycle makes it low. Mode 0 drives the pointer as the address and leaves the pointer unchanged.
- R3: Modes 1 (step +1) and 2 (step -1) drive the old pointer as the address, then store the stepped pointer.
- R4: Modes 3 (step +1) and 4 (step -1) step the pointer first. The stepped value is both the address and the stored pointer.
- R5: Mode 5 drives pointer plus the sign-extended 8-bit `req_off`, modulo 2^16, and leaves the pointer unchanged.
- R6: Mode 6 drives pointer plus the step register, modulo 2^16, and leaves the pointer unchanged.
- R7: Modes 7 and 8 drive the old pointer, then add (7) or subtract (8) the step register. Modes 9 and 10 add (9) or subtract (10) first, and the new value is the address. Codes 11 to 15 behave as mode 0.
- R8: With a non-zero length L, a stepped pointer keeps its upper bits above log2(K). Its low offset wraps so that it stays in 0..L-1, provided the step does not exceed L.
- R9: With a length of zero, stepping wraps modulo 2^16 (0xFFFF + 1 = 0x0000).
- R10: A write to the selected register in the same cycle as a request is seen by that request. A write-back by the request overrides the pointer write.
- R11: A request changes only the pointer it selects. No other register changes.
- R12: The read port returns the stored register selected by `rd_bank` (0 pointer, 1 step, 2 length) and `rd_reg`. The write port uses the same bank codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Bank to write: 0 pointer, 1 step, 2 length |
| wr_reg | input | 3 | Register number to write |
| wr_data | input | 16 | Write data |
| req | input | 1 | Address request strobe |
| req_reg | input | 3 | Pointer used by the request |
| req_mode | input | 4 | Addressing mode code |
| req_off | input | 8 | Signed constant offset for mode 5 |
| ea | output | 16 | Registered effective address |
| ea_valid | output | 1 | Address valid, one cycle after `req` |
| rd_bank | input | 2 | Bank to read back |
| rd_reg | input | 3 | Register number to read back |
| rd_data | output | 16 | Read-back data |

## Verification
A software write to a register and an address request on that same register can occur in the same clock. The bench provokes this by writing a new pointer and a new length in the very cycle a post-step request selects that pointer. It then checks that the address is the freshly written value and that the read-back shows the stepped, wrapped result rather than the written one. The cycle-by-cycle reference model applies the write before the request on every edge, so the same collision is also judged inside the random sequence.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  typedef enum logic [3:0] {
    MD_PLAIN     = 4'd0,
    MD_POST_INC  = 4'd1,
    MD_POST_DEC  = 4'd2,
    MD_PRE_INC   = 4'd3,
    MD_PRE_DEC   = 4'd4,
    MD_IDX_CONST = 4'd5,
    MD_IDX_REG   = 4'd6,
    MD_POST_ADDN = 4'd7,
    MD_POST_SUBN = 4'd8,
    MD_PRE_ADDN  = 4'd9,
    MD_PRE_SUBN  = 4'd10
  } agu_mode_e;

  typedef enum logic [1:0] {
    BK_PTR  = 2'd0,
    BK_STEP = 2'd1,
    BK_LEN  = 2'd2
  } agu_bank_e;
endpackage

// File: rtl/agu_regbank.sv
`timescale 1ns/1ps
module agu_regbank
  import agu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_bank,
  input  logic [RW-1:0] wr_reg,
  input  logic [AW-1:0] wr_data,
  input  logic          wb_en,
  input  logic [RW-1:0] wb_reg,
  input  logic [AW-1:0] wb_val,
  input  logic [RW-1:0] op_reg,
  output logic [AW-1:0] op_a,
  output logic [AW-1:0] op_n,
  output logic [AW-1:0] op_l,
  input  logic [1:0]    rd_bank,
  input  logic [RW-1:0] rd_reg,
  output logic [AW-1:0] rd_data
);
  logic [AW-1:0] ptr_q  [NREG];
  logic [AW-1:0] step_q [NREG];
  logic [AW-1:0] len_q  [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        ptr_q[i]  <= '0;
        step_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else begin
      if (wr_en) begin
        case (agu_bank_e'(wr_bank))
          BK_PTR:  ptr_q[wr_reg]  <= wr_data;
          BK_STEP: step_q[wr_reg] <= wr_data;
          BK_LEN:  len_q[wr_reg]  <= wr_data;
          default: ;
        endcase
      end
      // write-back comes later so it wins over a pointer write
      if (wb_en) ptr_q[wb_reg] <= wb_val;
    end
  end

  logic hit_ptr, hit_step, hit_len;
  always_comb begin
    hit_ptr  = wr_en && (wr_reg == op_reg) && (wr_bank == BK_PTR);
    hit_step = wr_en && (wr_reg == op_reg) && (wr_bank == BK_STEP);
    hit_len  = wr_en && (wr_reg == op_reg) && (wr_bank == BK_LEN);
    op_a = hit_ptr  ? wr_data : ptr_q[op_reg];
    op_n = hit_step ? wr_data : step_q[op_reg];
    op_l = hit_len  ? wr_data : len_q[op_reg];
  end

  always_comb begin
    case (agu_bank_e'(rd_bank))
      BK_PTR:  rd_data = ptr_q[rd_reg];
      BK_STEP: rd_data = step_q[rd_reg];
      BK_LEN:  rd_data = len_q[rd_reg];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/agu_calc.sv
`timescale 1ns/1ps
module agu_calc
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic [3:0]    mode,
  input  logic [AW-1:0] op_a,
  input  logic [AW-1:0] op_n,
  input  logic [AW-1:0] op_l,
  input  logic [OW-1:0] off,
  output logic [AW-1:0] ea_nxt,
  output logic          wb_req,
  output logic [AW-1:0] wb_val
);
  // smallest all-ones mask covering len-1
  function automatic logic [AW-1:0] span_mask(input logic [AW-1:0] len);
    logic [AW-1:0] m;
    m = len - 1'b1;
    for (int k = 1; k < AW; k = k * 2) m = m | (m >> k);
    return m;
  endfunction

  function automatic logic [AW-1:0] circ_step(input logic [AW-1:0] a,
                                              input logic [AW-1:0] l,
                                              input logic [AW-1:0] s,
                                              input logic          sub);
    logic [AW-1:0] m, o;
    logic [AW:0]   t;
    if (l == '0) return sub ? a - s : a + s;
    m = span_mask(l);
    o = a & m;
    if (!sub) begin
      t = {1'b0, o} + {1'b0, s};
      if (t >= {1'b0, l}) t = t - {1'b0, l};
    end else if (o >= s) begin
      t = {1'b0, o - s};
    end else begin
      t = {1'b0, o} + {1'b0, l} - {1'b0, s};
    end
    return (a & ~m) | t[AW-1:0];
  endfunction

  logic          use_n, go_down;
  logic [AW-1:0] step_amt, stepped;

  always_comb begin
    use_n    = mode inside {MD_POST_ADDN, MD_POST_SUBN, MD_PRE_ADDN, MD_PRE_SUBN};
    go_down  = mode inside {MD_POST_DEC, MD_PRE_DEC, MD_POST_SUBN, MD_PRE_SUBN};
    step_amt = use_n ? op_n : AW'(1);
    stepped  = circ_step(op_a, op_l, step_amt, go_down);
  end

  always_comb begin
    ea_nxt = op_a;
    wb_req = 1'b0;
    wb_val = stepped;
    case (agu_mode_e'(mode))
      MD_POST_INC, MD_POST_DEC, MD_POST_ADDN, MD_POST_SUBN: wb_req = 1'b1;
      MD_PRE_INC, MD_PRE_DEC, MD_PRE_ADDN, MD_PRE_SUBN: begin
        wb_req = 1'b1;
        ea_nxt = stepped;
      end
      MD_IDX_CONST: ea_nxt = op_a + {{(AW-OW){off[OW-1]}}, off};
      MD_IDX_REG:   ea_nxt = op_a + op_n;
      default:      ea_nxt = op_a;
    endcase
  end
endmodule

// File: rtl/agu_top.sv
`timescale 1ns/1ps
module agu_top #(
  parameter int NREG = 8,
  parameter int AW   = 16,
  parameter int OW   = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_bank,
  input  logic [RW-1:0] wr_reg,
  input  logic [AW-1:0] wr_data,
  input  logic          req,
  input  logic [RW-1:0] req_reg,
  input  logic [3:0]    req_mode,
  input  logic [OW-1:0] req_off,
  output logic [AW-1:0] ea,
  output logic          ea_valid,
  input  logic [1:0]    rd_bank,
  input  logic [RW-1:0] rd_reg,
  output logic [AW-1:0] rd_data
);
  // internal events, named for the checker
  logic [AW-1:0] op_a, op_n, op_l;
  logic [AW-1:0] ea_nxt, wb_val;
  logic          wb_req, wb_fire;

  assign wb_fire = req & wb_req;

  agu_regbank #(.NREG(NREG), .AW(AW)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_reg(wr_reg), .wr_data(wr_data),
    .wb_en(wb_fire), .wb_reg(req_reg), .wb_val(wb_val),
    .op_reg(req_reg), .op_a(op_a), .op_n(op_n), .op_l(op_l),
    .rd_bank(rd_bank), .rd_reg(rd_reg), .rd_data(rd_data)
  );

  agu_calc #(.AW(AW), .OW(OW)) calc_i (
    .mode(req_mode), .op_a(op_a), .op_n(op_n), .op_l(op_l), .off(req_off),
    .ea_nxt(ea_nxt), .wb_req(wb_req), .wb_val(wb_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea       <= '0;
      ea_valid <= 1'b0;
    end else begin
      ea_valid <= req;
      if (req) ea <= ea_nxt;
    end
  end
endmodule

// File: rtl/agu_chk.sv
`timescale 1ns/1ps
module agu_chk
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic [3:0]    req_mode,
  input logic [AW-1:0] ea,
  input logic          ea_valid,
  input logic [AW-1:0] op_a,
  input logic [AW-1:0] op_n,
  input logic [AW-1:0] op_l,
  input logic [AW-1:0] ea_nxt,
  input logic          wb_fire,
  input logic [AW-1:0] wb_val
);
  logic [AW-1:0] bmask;
  logic is_post, is_pre, is_noupd;
  always_comb begin
    bmask = '0;
    for (int i = 0; i < AW; i++) if ((AW'(1) << i) < op_l) bmask[i] = 1'b1;
    is_post  = req_mode inside {MD_POST_INC, MD_POST_DEC, MD_POST_ADDN, MD_POST_SUBN};
    is_pre   = req_mode inside {MD_PRE_INC, MD_PRE_DEC, MD_PRE_ADDN, MD_PRE_SUBN};
    is_noupd = req_mode inside {MD_PLAIN, MD_IDX_CONST, MD_IDX_REG};
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req |=> ea_valid); // R2
  AST_IDLE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n) !req |=> !ea_valid); // R2
  AST_POST_OLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (req && is_post) |=> ea == $past(op_a)); // R3
  AST_PRE_ADDR_IS_WB: assert property (@(posedge clk) disable iff (!rst_n) (req && is_pre) |-> (wb_fire && ea_nxt == wb_val)); // R4
  AST_INDEXED_NO_WB: assert property (@(posedge clk) disable iff (!rst_n) (req && is_noupd) |-> !wb_fire); // R5
  AST_WRAP_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && op_l != '0 && op_n <= op_l && (op_a & bmask) < op_l)
      |-> ((wb_val & ~bmask) == (op_a & ~bmask) && (wb_val & bmask) < op_l)); // R8
  AST_LINEAR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && op_l == '0 && req_mode == MD_POST_INC) |-> wb_val == op_a + 1'b1); // R9
  AST_NO_REQ_NO_WB: assert property (@(posedge clk) disable iff (!rst_n) !req |-> !wb_fire); // R11
endmodule

bind agu_top agu_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .req_mode(req_mode),
  .ea(ea), .ea_valid(ea_valid), .op_a(op_a), .op_n(op_n), .op_l(op_l),
  .ea_nxt(ea_nxt), .wb_fire(wb_fire), .wb_val(wb_val)
);

// File: tb/agu_top_tb.sv
`timescale 1ns/1ps
module agu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_bank = '0;
  logic [2:0]  wr_reg = '0;
  logic [15:0] wr_data = '0;
  logic        req = 1'b0;
  logic [2:0]  req_reg = '0;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_off = '0;
  logic [15:0] ea;
  logic        ea_valid;
  logic [1:0]  rd_bank = '0;
  logic [2:0]  rd_reg = '0;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;
  int mp[8], mn[8], ml[8];

  always #4 clk = ~clk;

  agu_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_reg(wr_reg),
    .wr_data(wr_data), .req(req), .req_reg(req_reg), .req_mode(req_mode),
    .req_off(req_off), .ea(ea), .ea_valid(ea_valid), .rd_bank(rd_bank),
    .rd_reg(rd_reg), .rd_data(rd_data)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural wrap: find the power-of-two block, step inside it
  function automatic int mstep(input int a, input int l, input int s, input bit down);
    int k, base, o;
    if (l == 0) return down ? ((a - s) & 'hFFFF) : ((a + s) & 'hFFFF);
    k = 1;
    while (k < l) k = k * 2;
    base = a - (a % k);
    o = a % k;
    o = down ? o - s : o + s;
    if (o >= l) o = o - l;
    if (o < 0) o = o + l;
    return base + o;
  endfunction

  task automatic cyc(input bit dw, input int bk, input int wr, input int wd,
                     input bit dq, input int rr, input int md, input int off,
                     input string tag);
    int a, e, so;
    @(negedge clk);
    wr_en = dw; wr_bank = 2'(bk); wr_reg = 3'(wr); wr_data = 16'(wd);
    req = dq; req_reg = 3'(rr); req_mode = 4'(md); req_off = 8'(off);
    if (dw) begin
      if (bk == 0) mp[wr] = wd & 'hFFFF;
      if (bk == 1) mn[wr] = wd & 'hFFFF;
      if (bk == 2) ml[wr] = wd & 'hFFFF;
    end
    e = 0;
    if (dq) begin
      a = mp[rr];
      so = int'($signed(8'(off)));
      case (md)
        1: begin e = a; mp[rr] = mstep(a, ml[rr], 1, 0); end
        2: begin e = a; mp[rr] = mstep(a, ml[rr], 1, 1); end
        3: begin mp[rr] = mstep(a, ml[rr], 1, 0); e = mp[rr]; end
        4: begin mp[rr] = mstep(a, ml[rr], 1, 1); e = mp[rr]; end
        5: e = (a + so) & 'hFFFF;
        6: e = (a + mn[rr]) & 'hFFFF;
        7: begin e = a; mp[rr] = mstep(a, ml[rr], mn[rr], 0); end
        8: begin e = a; mp[rr] = mstep(a, ml[rr], mn[rr], 1); end
        9: begin mp[rr] = mstep(a, ml[rr], mn[rr], 0); e = mp[rr]; end
        10: begin mp[rr] = mstep(a, ml[rr], mn[rr], 1); e = mp[rr]; end
        default: e = a;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; req = 1'b0;
    chk(int'(ea_valid), int'(dq), {tag, " valid"});
    if (dq) chk(int'(ea), e, {tag, " addr"});
  endtask

  task automatic rb(input int bk, input int r, input string tag);
    int exp;
    rd_bank = 2'(bk); rd_reg = 3'(r);
    #1;
    exp = (bk == 0) ? mp[r] : (bk == 1) ? mn[r] : (bk == 2) ? ml[r] : 0;
    chk(int'(rd_data), exp, tag);
  endtask

  task automatic rb_all(input string tag);
    for (int r = 0; r < 8; r++)
      for (int b = 0; b < 3; b++) rb(b, r, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mp[i] = 0; mn[i] = 0; ml[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(int'(ea_valid), 0, "R1 valid after reset");
    rb_all("R1 reset readback");

    // linear pointer 0
    cyc(1, 0, 0, 'h0100, 0, 0, 0, 0, "R12 load ptr");
    cyc(1, 1, 0, 3, 0, 0, 0, 0, "R12 load step");
    rb(0, 0, "R12 ptr readback"); rb(1, 0, "R12 step readback");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R2 plain");
    rb(0, 0, "R2 ptr unchanged");
    cyc(0, 0, 0, 0, 1, 0, 1, 0, "R3 post inc");
    cyc(0, 0, 0, 0, 1, 0, 2, 0, "R3 post dec");
    cyc(0, 0, 0, 0, 1, 0, 2, 0, "R3 post dec again");
    rb(0, 0, "R3 ptr after post");
    chk(int'(rd_data), 'h00FF, "R3 ptr literal");
    cyc(0, 0, 0, 0, 1, 0, 3, 0, "R4 pre inc");
    cyc(0, 0, 0, 0, 1, 0, 4, 0, "R4 pre dec");
    cyc(0, 0, 0, 0, 1, 0, 5, 5, "R5 const +5");
    cyc(0, 0, 0, 0, 1, 0, 5, -7, "R5 const -7");
    rb(0, 0, "R5 ptr unchanged");
    cyc(0, 0, 0, 0, 1, 0, 6, 0, "R6 by step reg");
    rb(0, 0, "R6 ptr unchanged");
    cyc(0, 0, 0, 0, 1, 0, 7, 0, "R7 post add N");
    cyc(0, 0, 0, 0, 1, 0, 8, 0, "R7 post sub N");
    cyc(0, 0, 0, 0, 1, 0, 9, 0, "R7 pre add N");
    cyc(0, 0, 0, 0, 1, 0, 10, 0, "R7 pre sub N");
    cyc(0, 0, 0, 0, 1, 0, 13, 0, "R7 unused code as plain");
    rb(0, 0, "R7 ptr after combined");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");

    // circular pointer 1: base 0x200, length 6 (block of 8)
    cyc(1, 0, 1, 'h0203, 0, 0, 0, 0, "R8 load ptr");
    cyc(1, 2, 1, 6, 0, 0, 0, 0, "R8 load len");
    cyc(1, 1, 1, 4, 0, 0, 0, 0, "R8 load step");
    cyc(0, 0, 0, 0, 1, 1, 1, 0, "R8 post inc");
    cyc(0, 0, 0, 0, 1, 1, 1, 0, "R8 post inc");
    cyc(0, 0, 0, 0, 1, 1, 1, 0, "R8 post inc to end");
    rb(0, 1, "R8 wrapped to base");
    chk(int'(rd_data), 'h0200, "R8 wrap literal");
    cyc(0, 0, 0, 0, 1, 1, 4, 0, "R8 pre dec below base");
    chk(int'(ea), 'h0205, "R8 pre dec literal");
    cyc(0, 0, 0, 0, 1, 1, 9, 0, "R8 pre add N wraps");
    chk(int'(ea), 'h0203, "R8 add N literal");
    cyc(0, 0, 0, 0, 1, 1, 10, 0, "R8 pre sub N wraps");
    chk(int'(ea), 'h0205, "R8 sub N literal");

    // linear edge pointer 2
    cyc(1, 0, 2, 'hFFFF, 0, 0, 0, 0, "R9 load ptr");
    cyc(0, 0, 0, 0, 1, 2, 1, 0, "R9 post inc at top");
    rb(0, 2, "R9 wrapped to zero");
    chk(int'(rd_data), 0, "R9 zero literal");
    cyc(0, 0, 0, 0, 1, 2, 4, 0, "R9 pre dec at zero");
    chk(int'(ea), 'hFFFF, "R9 top literal");

    // same-cycle write and request, pointer 3
    cyc(1, 2, 3, 5, 0, 0, 0, 0, "R10 load len");
    cyc(1, 0, 3, 'h0404, 1, 3, 1, 0, "R10 ptr write with post inc");
    chk(int'(ea), 'h0404, "R10 sees new ptr");
    rb(0, 3, "R10 write-back wins");
    chk(int'(rd_data), 'h0400, "R10 wrapped literal");
    cyc(1, 2, 3, 0, 1, 3, 2, 0, "R10 len write with post dec");
    rb(0, 3, "R10 linear after len clear");
    rb_all("R11 all registers");

    // random circular traffic on pointers 4..7
    for (int r = 4; r < 8; r++) begin
      int l;
      l = 1 + int'($urandom_range(39));
      cyc(1, 2, r, l, 0, 0, 0, 0, "R8 rnd len");
      cyc(1, 1, r, 1 + int'($urandom_range(l - 1)), 0, 0, 0, 0, "R8 rnd step");
      cyc(1, 0, r, r * 'h100 + int'($urandom_range(l - 1)), 0, 0, 0, 0, "R8 rnd ptr");
    end
    for (int i = 0; i < 300; i++)
      cyc(0, 0, 0, 0, 1'($urandom_range(1)), 4 + int'($urandom_range(3)),
          int'($urandom_range(15)), int'($urandom_range(255)), "R11 random op");
    rb_all("R11 final registers");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule